// File: doc/BRIEF.md
# Channel Interrupt Mask Controller

This block collects completion events from a multi-channel DMA engine and turns them into one interrupt line for a host processor. It holds three interrupt groups. The transmit group and the receive group each have one raw status bit and one enable bit per channel. A small DMA group holds a single host-error source. Software reaches all of them through a plain register port: an address, write data, a write enable and combinational read data.

Each event pulse sets a raw bit that stays set. Software can read it either unfiltered or filtered by the enable mask. The masks change only through paired write-one-to-set and write-one-to-clear addresses, so bits that are written as zero are never disturbed. A raw bit is acknowledged by writing a one to it at its raw-status address. A write to the end-of-interrupt address forces the interrupt line low for one cycle, so that a level-sensitive host controller sees a fresh edge if work is still pending.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, every raw and enable bit is zero, `irq` is low and every register reads zero.
- R2: A one on `tx_done[i]` or `rx_done[i]` in a cycle sets raw bit i of that direction from the next cycle on. The bit stays set until it is acknowledged.
- R3: A write to a mask-set address (0x88 transmit, 0xA8 receive, 0xB8 DMA) ORs the written ones into that group's mask. Zero bits leave the mask unchanged. Reading a mask-set or mask-clear address returns the current mask.
- R4: A write to a mask-clear address (0x8C, 0xAC, 0xBC) clears the mask bits written as one. All ones disables the whole group in one write.
- R5: The masked-status addresses (0x84, 0xA4, 0xB4) always read raw AND mask for their group.
- R6: Writing ones to a raw-status address (0x80, 0xA0, 0xB0) clears those raw bits. An event arriving in the same cycle as the clear wins, and its bit stays set.
- R7: `irq` is high exactly when at least one masked status bit is set in any group, except in the cycle given by R8.
- R8: A write to 0x94 (end of interrupt) holds `irq` low for the one cycle after the write. After that cycle `irq` follows R7 again. The write data is ignored and the address reads zero.
- R9: A read of an undefined offset returns zero, and a write to one changes nothing. Raw and mask bits above the channel count, and DMA-group bits other than bit 1, read zero.
- R10: `host_err` sets bit 1 of the DMA group raw status, and that bit obeys R3 to R7 like a channel bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register byte offset, used for both read and write |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rdata | output | 32 | Read data of the register at `addr` (combinational) |
| tx_done | input | NUM_CH | Transmit completion pulses, one per channel |
| rx_done | input | NUM_CH | Receive completion pulses, one per channel |
| host_err | input | 1 | Host error pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong raw bit or mask bit shows at the ports within one cycle, through the masked-status read of its group and through `irq`. The bench reads a register after every random operation, so any divergence from the reference model is caught at the next read of the affected register. Faults in the set-priority and end-of-interrupt timing show only in a single cycle, so directed cases sample that cycle exactly.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    // Read data width of the register port
    localparam int REG_W        = 32;
    // DMA group: two bit positions, only the host-error bit is implemented
    localparam int DMA_W        = 2;
    localparam int HOST_ERR_BIT = 1;
    localparam logic [DMA_W-1:0] DMA_IMPL = 2'b10;

    // Register byte offsets that software decodes
    localparam logic [7:0] OFS_TX_RAW = 8'h80;
    localparam logic [7:0] OFS_TX_MSK = 8'h84;
    localparam logic [7:0] OFS_TX_SET = 8'h88;
    localparam logic [7:0] OFS_TX_CLR = 8'h8C;
    localparam logic [7:0] OFS_EOI    = 8'h94;
    localparam logic [7:0] OFS_RX_RAW = 8'hA0;
    localparam logic [7:0] OFS_RX_MSK = 8'hA4;
    localparam logic [7:0] OFS_RX_SET = 8'hA8;
    localparam logic [7:0] OFS_RX_CLR = 8'hAC;
    localparam logic [7:0] OFS_DM_RAW = 8'hB0;
    localparam logic [7:0] OFS_DM_MSK = 8'hB4;
    localparam logic [7:0] OFS_DM_SET = 8'hB8;
    localparam logic [7:0] OFS_DM_CLR = 8'hBC;

    // Which interrupt group an offset belongs to
    typedef enum logic [1:0] {
        GRP_NONE,
        GRP_TX,
        GRP_RX,
        GRP_DMA
    } grp_e;

    // What kind of access an offset performs
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RAW,
        ACC_MSK,
        ACC_SET,
        ACC_CLR,
        ACC_EOI
    } acc_e;

    typedef struct packed {
        grp_e grp;
        acc_e acc;
    } dec_t;

endpackage

// File: rtl/irqm_decode.sv
// Address decoder.
// What it does: maps a byte offset to an interrupt group and an access kind.
// Assumes: ADDR_W >= 8. Any set address bit above bit 7 selects no register.
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    logic       in_page;
    logic [7:0] ofs;

    // Only the first 256-byte page holds registers
    assign in_page = ((addr >> 8) == '0);
    assign ofs     = addr[7:0];

    // Offset to (group, access) lookup
    always_comb begin
        dec = '{grp: GRP_NONE, acc: ACC_NONE};
        if (in_page) begin
            unique case (ofs)
                OFS_TX_RAW: dec = '{grp: GRP_TX,   acc: ACC_RAW};
                OFS_TX_MSK: dec = '{grp: GRP_TX,   acc: ACC_MSK};
                OFS_TX_SET: dec = '{grp: GRP_TX,   acc: ACC_SET};
                OFS_TX_CLR: dec = '{grp: GRP_TX,   acc: ACC_CLR};
                OFS_RX_RAW: dec = '{grp: GRP_RX,   acc: ACC_RAW};
                OFS_RX_MSK: dec = '{grp: GRP_RX,   acc: ACC_MSK};
                OFS_RX_SET: dec = '{grp: GRP_RX,   acc: ACC_SET};
                OFS_RX_CLR: dec = '{grp: GRP_RX,   acc: ACC_CLR};
                OFS_DM_RAW: dec = '{grp: GRP_DMA,  acc: ACC_RAW};
                OFS_DM_MSK: dec = '{grp: GRP_DMA,  acc: ACC_MSK};
                OFS_DM_SET: dec = '{grp: GRP_DMA,  acc: ACC_SET};
                OFS_DM_CLR: dec = '{grp: GRP_DMA,  acc: ACC_CLR};
                OFS_EOI:    dec = '{grp: GRP_NONE, acc: ACC_EOI};
                default:    dec = '{grp: GRP_NONE, acc: ACC_NONE};
            endcase
        end
    end

endmodule

// File: rtl/irqm_bank.sv
// Interrupt bank.
// What it does: holds one raw status bit and one enable bit per source.
//   Raw bits set on an event and clear on a write-one acknowledge; the event
//   wins a tie. Enable bits change only through set and clear strobes.
// Assumes: set_we and clr_we are never both high (the decoder guarantees it).
//   Bits whose IMPL bit is zero are not built and read zero.
module irqm_bank #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] IMPL  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic [WIDTH-1:0] wbits,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic             ack_we,
    output logic [WIDTH-1:0] raw_q,
    output logic [WIDTH-1:0] mask_q,
    output logic             pend
);

    logic unused_bits;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic raw_r;
            logic msk_r;

            // Raw status: set by the event, cleared by a write-one acknowledge
            always_ff @(posedge clk) begin
                if (!rst_n)                  raw_r <= 1'b0;
                else if (evt[i])             raw_r <= 1'b1;
                else if (ack_we && wbits[i]) raw_r <= 1'b0;
            end

            // Enable bit: set and clear strobes touch only the bits written as one
            always_ff @(posedge clk) begin
                if (!rst_n)                  msk_r <= 1'b0;
                else if (set_we && wbits[i]) msk_r <= 1'b1;
                else if (clr_we && wbits[i]) msk_r <= 1'b0;
            end

            assign raw_q[i]  = raw_r;
            assign mask_q[i] = msk_r;
        end else begin : g_tied
            assign raw_q[i]  = 1'b0;
            assign mask_q[i] = 1'b0;
        end
    end

    // Pending when any enabled source has its raw bit set
    assign pend = |(raw_q & mask_q);

    assign unused_bits = ^((evt | wbits) & ~IMPL);

endmodule

// File: rtl/irqm_rdmux.sv
// Read multiplexer.
// What it does: returns the raw, masked or mask view of the decoded group,
//   zero-extended to the register width. Returns zero for any other access.
// Assumes: NUM_CH <= REG_W.
module irqm_rdmux
    import irqm_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  dec_t              dec,
    input  logic [NUM_CH-1:0] tx_raw,
    input  logic [NUM_CH-1:0] tx_msk,
    input  logic [NUM_CH-1:0] rx_raw,
    input  logic [NUM_CH-1:0] rx_msk,
    input  logic [DMA_W-1:0]  dm_raw,
    input  logic [DMA_W-1:0]  dm_msk,
    output logic [REG_W-1:0]  rdata
);

    logic [REG_W-1:0] g_raw;
    logic [REG_W-1:0] g_msk;

    // Pick the selected group's vectors
    always_comb begin
        g_raw = '0;
        g_msk = '0;
        unique case (dec.grp)
            GRP_TX:  begin g_raw = REG_W'(tx_raw); g_msk = REG_W'(tx_msk); end
            GRP_RX:  begin g_raw = REG_W'(rx_raw); g_msk = REG_W'(rx_msk); end
            GRP_DMA: begin g_raw = REG_W'(dm_raw); g_msk = REG_W'(dm_msk); end
            default: begin g_raw = '0;             g_msk = '0;             end
        endcase
    end

    // Pick the view by access kind
    always_comb begin
        unique case (dec.acc)
            ACC_RAW:          rdata = g_raw;
            ACC_MSK:          rdata = g_raw & g_msk;
            ACC_SET, ACC_CLR: rdata = g_msk;
            default:          rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqm_eoi.sv
// End-of-interrupt gate.
// What it does: blanks the combined request for the one cycle after an
//   end-of-interrupt write, so a pending request shows a fresh rising edge.
// Assumes: eoi_we is a single-cycle write strobe.
module irqm_eoi (
    input  logic clk,
    input  logic rst_n,
    input  logic eoi_we,
    input  logic pend_any,
    output logic irq
);

    logic hold_q;

    // Remember that the last cycle held an end-of-interrupt write
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= eoi_we;
    end

    assign irq = pend_any & ~hold_q;

endmodule

// File: rtl/irq_mask_ctrl.sv
// Channel interrupt mask controller (top).
// What it does: transmit, receive and DMA interrupt groups behind one
//   register port, combined into one interrupt line with end-of-interrupt
//   re-arm.
// Assumes: 1 <= NUM_CH <= 32 and ADDR_W >= 8. Event inputs are synchronous
//   to clk.
module irq_mask_ctrl
    import irqm_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr_en,
    output logic [REG_W-1:0]  rdata,
    input  logic [NUM_CH-1:0] tx_done,
    input  logic [NUM_CH-1:0] rx_done,
    input  logic              host_err,
    output logic              irq
);

    localparam int GRP_N = 3;

    dec_t              dec;
    logic [GRP_N-1:0]  set_we;
    logic [GRP_N-1:0]  clr_we;
    logic [GRP_N-1:0]  ack_we;
    logic [GRP_N-1:0]  pend;
    logic              eoi_we;
    logic [NUM_CH-1:0] tx_raw, tx_msk, rx_raw, rx_msk;
    logic [DMA_W-1:0]  dm_raw, dm_msk, dm_evt;
    logic              wdata_unused;

    irqm_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    // Per-group write strobes from the decoded access
    for (genvar g = 0; g < GRP_N; g++) begin : g_stb
        localparam grp_e GSEL = (g == 0) ? GRP_TX : (g == 1) ? GRP_RX : GRP_DMA;
        assign set_we[g] = wr_en && (dec.grp == GSEL) && (dec.acc == ACC_SET);
        assign clr_we[g] = wr_en && (dec.grp == GSEL) && (dec.acc == ACC_CLR);
        assign ack_we[g] = wr_en && (dec.grp == GSEL) && (dec.acc == ACC_RAW);
    end

    assign eoi_we = wr_en && (dec.acc == ACC_EOI);

    // Host error drives its fixed bit of the DMA group
    always_comb begin
        dm_evt               = '0;
        dm_evt[HOST_ERR_BIT] = host_err;
    end

    irqm_bank #(.WIDTH(NUM_CH), .IMPL({NUM_CH{1'b1}})) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (tx_done),
        .wbits  (wdata[NUM_CH-1:0]),
        .set_we (set_we[0]),
        .clr_we (clr_we[0]),
        .ack_we (ack_we[0]),
        .raw_q  (tx_raw),
        .mask_q (tx_msk),
        .pend   (pend[0])
    );

    irqm_bank #(.WIDTH(NUM_CH), .IMPL({NUM_CH{1'b1}})) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (rx_done),
        .wbits  (wdata[NUM_CH-1:0]),
        .set_we (set_we[1]),
        .clr_we (clr_we[1]),
        .ack_we (ack_we[1]),
        .raw_q  (rx_raw),
        .mask_q (rx_msk),
        .pend   (pend[1])
    );

    irqm_bank #(.WIDTH(DMA_W), .IMPL(DMA_IMPL)) u_dma (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (dm_evt),
        .wbits  (wdata[DMA_W-1:0]),
        .set_we (set_we[2]),
        .clr_we (clr_we[2]),
        .ack_we (ack_we[2]),
        .raw_q  (dm_raw),
        .mask_q (dm_msk),
        .pend   (pend[2])
    );

    irqm_rdmux #(.NUM_CH(NUM_CH)) u_rd (
        .dec    (dec),
        .tx_raw (tx_raw),
        .tx_msk (tx_msk),
        .rx_raw (rx_raw),
        .rx_msk (rx_msk),
        .dm_raw (dm_raw),
        .dm_msk (dm_msk),
        .rdata  (rdata)
    );

    irqm_eoi u_eoi (
        .clk      (clk),
        .rst_n    (rst_n),
        .eoi_we   (eoi_we),
        .pend_any (|pend),
        .irq      (irq)
    );

    assign wdata_unused = ^wdata;

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
// Assertion checker for irq_mask_ctrl, attached by the bind at the end of this file.
module irq_mask_ctrl_chk #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              wr_en,
    input logic [NUM_CH-1:0] tx_done,
    input logic              host_err,
    input logic              irq,
    input logic [NUM_CH-1:0] tx_raw,
    input logic [NUM_CH-1:0] tx_msk,
    input logic [NUM_CH-1:0] rx_raw,
    input logic [NUM_CH-1:0] rx_msk,
    input logic [1:0]        dm_raw,
    input logic [1:0]        dm_msk
);

    // R1: reset empties every raw and enable bit
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (tx_raw == '0 && tx_msk == '0 && rx_raw == '0 &&
                    rx_msk == '0 && dm_raw == '0 && dm_msk == '0));

    // R2: a transmit event is visible in raw status on the next cycle
    p_event_sets_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_done) |=> ((tx_raw & $past(tx_done)) == $past(tx_done)));

    // R6: raw bits stay set unless their raw address is written
    p_raw_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(8'h80)) |=> ((tx_raw & $past(tx_raw)) == $past(tx_raw)));

    // R3: a mask-set write leaves every written one enabled
    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'hA8)) |=>
            ((rx_msk & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0])));

    // R4: a mask-clear write leaves every written one disabled
    p_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h8C)) |=> ((tx_msk & $past(wdata[NUM_CH-1:0])) == '0));

    // R7: no masked bit anywhere means no request
    p_no_masked_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_raw & tx_msk) == '0 && (rx_raw & rx_msk) == '0 && (dm_raw & dm_msk) == '0) |-> !irq);

    // R8: the cycle after an end-of-interrupt write is quiet
    p_eoi_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h94)) |=> !irq);

    // R10: a host error sets DMA raw bit 1
    p_host_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> dm_raw[1]);

    // R9: the unimplemented DMA bit never sets
    p_dma_bit0_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dm_raw[0] && !dm_msk[0]);

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .tx_done  (tx_done),
    .host_err (host_err),
    .irq      (irq),
    .tx_raw   (tx_raw),
    .tx_msk   (tx_msk),
    .rx_raw   (rx_raw),
    .rx_msk   (rx_msk),
    .dm_raw   (dm_raw),
    .dm_msk   (dm_msk)
);

// File: tb/irq_mask_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  tx_done = '0;
    logic [7:0]  rx_done = '0;
    logic        host_err = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    logic [7:0] mtx = '0, mrx = '0, rtx = '0, rrx = '0;
    logic [1:0] mdm = '0, rdm = '0;
    logic       eoi_last = 1'b0;

    always #10 clk = ~clk;

    irq_mask_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rdata    (rdata),
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .host_err (host_err),
        .irq      (irq)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h80: return {24'd0, rtx};
            8'h84: return {24'd0, rtx & mtx};
            8'h88, 8'h8C: return {24'd0, mtx};
            8'hA0: return {24'd0, rrx};
            8'hA4: return {24'd0, rrx & mrx};
            8'hA8, 8'hAC: return {24'd0, mrx};
            8'hB0: return {30'd0, rdm};
            8'hB4: return {30'd0, rdm & mdm};
            8'hB8, 8'hBC: return {30'd0, mdm};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (|(rtx & mtx) | |(rrx & mrx) | |(rdm & mdm)) & ~eoi_last;
    endfunction

    // Advance the model by one clock edge
    task automatic model_step(input logic [7:0] a, input logic [31:0] d, input logic we,
                              input logic [7:0] te, input logic [7:0] re, input logic he);
        logic [1:0] dd;
        dd = d[1:0] & 2'b10;
        if (we) begin
            case (a)
                8'h80: rtx &= ~d[7:0];
                8'h88: mtx |= d[7:0];
                8'h8C: mtx &= ~d[7:0];
                8'hA0: rrx &= ~d[7:0];
                8'hA8: mrx |= d[7:0];
                8'hAC: mrx &= ~d[7:0];
                8'hB0: rdm &= ~dd;
                8'hB8: mdm |= dd;
                8'hBC: mdm &= ~dd;
                default: ;
            endcase
        end
        rtx |= te;
        rrx |= re;
        if (he) rdm[1] = 1'b1;
        eoi_last = we && (a == 8'h94);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with the given stimulus, model updated, ending at a falling edge
    task automatic cyc(input logic [7:0] a, input logic [31:0] d, input logic we,
                       input logic [7:0] te, input logic [7:0] re, input logic he);
        @(negedge clk);
        addr = a; wdata = d; wr_en = we; tx_done = te; rx_done = re; host_err = he;
        @(negedge clk);
        wr_en = 1'b0; tx_done = '0; rx_done = '0; host_err = 1'b0;
        model_step(a, d, we, te, re, he);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        addr = a;
        #1;
        chk(req, rdata, exp_read(a));
    endtask

    task automatic irq_chk(input string req);
        chk(req, {31'd0, irq}, {31'd0, exp_irq()});
    endtask

    localparam logic [7:0] ADDRS [15] = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'h94,
                                         8'hA0, 8'hA4, 8'hA8, 8'hAC,
                                         8'hB0, 8'hB4, 8'hB8, 8'hBC, 8'h90, 8'h00};

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 15; i++) rd_chk("R1", ADDRS[i]);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2: event sets raw, not yet enabled so irq stays low
        cyc(8'h00, 0, 1'b0, 8'h08, 8'h00, 1'b0);
        rd_chk("R2", 8'h80);
        chk("R2 irq masked off", {31'd0, irq}, 32'd0);
        cyc(8'h00, 0, 1'b0, 8'h00, 8'h00, 1'b0);
        rd_chk("R2 sticky", 8'h80);

        // R3: mask set with zero bits leaving others alone
        cyc(8'h88, 32'h0000_0009, 1'b1, 0, 0, 0);
        cyc(8'h88, 32'h0000_0000, 1'b1, 0, 0, 0);
        rd_chk("R3", 8'h88);
        chk("R3 value", rdata, 32'h9);
        // R5 and R7: masked status and request
        rd_chk("R5", 8'h84);
        irq_chk("R7");

        // R8: end of interrupt blanks irq for one cycle only
        @(negedge clk);
        addr = 8'h94; wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_step(8'h94, 32'hFFFF_FFFF, 1'b1, 0, 0, 0);
        chk("R8 blank", {31'd0, irq}, 32'd0);
        rd_chk("R8 reads zero", 8'h94);
        @(negedge clk);
        eoi_last = 1'b0;
        chk("R8 rearm", {31'd0, irq}, 32'd1);

        // R6: event wins over simultaneous acknowledge
        cyc(8'h80, 32'hFF, 1'b1, 8'h01, 8'h00, 1'b0);
        rd_chk("R6", 8'h80);
        chk("R6 value", rdata, 32'h1);
        irq_chk("R6 irq");

        // R4: all ones clears the whole group
        cyc(8'hA8, 32'hFF, 1'b1, 0, 8'h81, 0);
        cyc(8'hAC, 32'hFFFF_FFFF, 1'b1, 0, 0, 0);
        rd_chk("R4", 8'hAC);
        chk("R4 value", rdata, 32'h0);
        rd_chk("R4 rx raw kept", 8'hA0);

        // R10: host error on bit 1
        cyc(8'hB8, 32'hFFFF_FFFF, 1'b1, 0, 0, 1'b1);
        rd_chk("R10", 8'hB4);
        chk("R10 value", rdata, 32'h2);
        irq_chk("R10 irq");

        // R9: undefined offset write has no effect
        cyc(8'h90, 32'hFFFF_FFFF, 1'b1, 0, 0, 0);
        rd_chk("R9 undef", 8'h90);
        for (int i = 0; i < 15; i++) rd_chk("R9 state", ADDRS[i]);

        // Random phase against the model
        for (int n = 0; n < 800; n++) begin
            logic [7:0]  a, ra, te, re;
            logic [31:0] d;
            logic        we, he;
            a  = ($urandom % 8 == 0) ? 8'($urandom) : ADDRS[$urandom % 15];
            d  = $urandom;
            we = ($urandom % 4 != 0);
            te = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            re = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            he = ($urandom % 10 == 0);
            cyc(a, d, we, te, re, he);
            ra = ($urandom % 8 == 0) ? 8'($urandom) : ADDRS[$urandom % 15];
            rd_chk("R5 R9 random read", ra);
            irq_chk("R7 R8 random irq");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule